// File: doc/BRIEF.md
# Timer and Watchdog with Shared Prescaler

This block combines an 8-bit timer/counter and a watchdog counter. One 8-bit prescaler serves whichever of the two it is assigned to. The timer counts either instruction-cycle strobes or edges on an external pin. Before it reaches the counter, the pin passes through a two-stage synchronizer and an edge detector. The watchdog counts ticks from a free-running oscillator, which keep coming during sleep. When it reaches a terminal count it raises a one-cycle reset request.

A 6-bit write-only mode register sets up the block:
- bit 5 picks the timer source (0 = cycle strobe, 1 = pin);
- bit 4 picks the pin edge (0 = rising, 1 = falling);
- bit 3 hands the prescaler to the timer (0) or to the watchdog (1);
- bits 2:0 give the ratio exponent.

The block also keeps the time-out (TO) and power-down (PD) status flags. It updates them on watchdog clears, on sleep, on timeouts and on master-clear resets.

Top module: `tmr_wdt_unit`

## Requirements
- R1: After power-on reset the timer reads 0, TO=1, PD=1, and the mode register holds binary 111111.
- R2: With mode bit 5 = 0 and bit 3 = 1, the timer adds one for each clock cycle in which the cycle strobe is high.
- R3: With mode bit 3 = 0, the timer advances once every 2^(bits 2:0 + 1) source events, so ratios run from 1:2 to 1:256.
- R4: With mode bit 5 = 1, the timer counts pin transitions of the kind chosen by bit 4 (0 rising, 1 falling). Transitions of the other kind are ignored. A pin change set up before clock edge k shows at the timer output after edge k+2.
- R5: A timer write loads the data and takes priority over an increment in the same cycle. It clears the prescaler when bit 3 = 0.
- R6: With bit 3 = 1, the watchdog advances once every 2^(bits 2:0) ticks. Its WDT_LIMIT-th advance produces a one-cycle wdt_rst pulse and sets TO=0. PD becomes 1 if the block was awake.
- R7: A watchdog-clear sets TO=1 and PD=1. It restarts the watchdog count and also clears the prescaler when bit 3 = 1.
- R8: Sleep sets TO=1 and PD=0 and restarts the watchdog count. A timeout during sleep leaves TO=0 and PD=0.
- R9: A master-clear returns the mode register to 111111. During sleep it gives TO=1 and PD=0. Outside sleep it leaves both flags unchanged.
- R10: A watchdog timeout returns the mode register to 111111.
- R11: While the timer owns the prescaler, the watchdog counts raw ticks 1:1. While the pin source is selected, the cycle strobe has no effect on the timer.
- R12: A mode write that changes bit 3 clears the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| cyc_stb_i | input | 1 | Instruction-cycle strobe |
| ext_pin_i | input | 1 | Asynchronous external count input |
| wdt_tick_i | input | 1 | Watchdog oscillator tick, one clock wide |
| mode_we_i | input | 1 | Mode register write strobe |
| mode_wdata_i | input | 6 | Mode register write data |
| tmr_we_i | input | 1 | Timer write strobe |
| tmr_wdata_i | input | TMR_W | Timer write data |
| clrwdt_i | input | 1 | Watchdog-clear strobe |
| sleep_i | input | 1 | Sleep-entry strobe |
| mclr_i | input | 1 | Master-clear reset strobe |
| tmr_o | output | TMR_W | Timer value |
| wdt_rst_o | output | 1 | Watchdog timeout reset pulse |
| to_o | output | 1 | Time-out status flag |
| pd_o | output | 1 | Power-down status flag |

## Verification
The bench builds the unit with WDT_LIMIT=4, keeping the default 8-bit timer and prescaler. The short terminal count makes a timeout take only a few ticks. This brings within reach:
- timeouts while awake and while asleep;
- a master-clear during sleep;
- the recovery of the mode register after a timeout.

The full 8-bit prescaler still allows the 1:256 timer ratio, and a ratio switch in the middle of a count that shows whether the prescaler was cleared.

// File: rtl/tmr_wdt_pkg.sv
package tmr_wdt_pkg;

    typedef struct packed {
        logic       ext_src;     // bit 5
        logic       fall_edge;   // bit 4
        logic       psc_to_wdt;  // bit 3
        logic [2:0] ratio_sel;   // bits 2:0
    } mode_t;

    localparam mode_t MODE_POR = '{ext_src: 1'b1, fall_edge: 1'b1,
                                   psc_to_wdt: 1'b1, ratio_sel: 3'b111};

endpackage

// File: rtl/pin_edge_sync.sv
module pin_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic fall_sel_i,
    output logic edge_o
);
    typedef struct packed {
        logic [SYNC_STAGES:0] sh;
    } st_t;

    st_t st_d, st_q;
    logic cur, prev;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[SYNC_STAGES-1:0], pin_i};
        cur     = st_q.sh[SYNC_STAGES-1];
        prev    = st_q.sh[SYNC_STAGES];
        edge_o  = fall_sel_i ? (prev & ~cur) : (~prev & cur);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/shared_prescaler.sv
module shared_prescaler #(
    parameter int PSC_W = 8,
    localparam int SHW  = $clog2(PSC_W + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr_i,
    input  logic           evt_i,
    input  logic [SHW-1:0] shift_i,
    output logic           ovf_o
);
    typedef struct packed {
        logic [PSC_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [PSC_W-1:0] nxt;
    logic [PSC_W:0]   one_hot, mask;

    always_comb begin
        st_d    = st_q;
        nxt     = st_q.cnt + PSC_W'(1);
        one_hot = (PSC_W+1)'(1) << shift_i;
        mask    = one_hot - (PSC_W+1)'(1);
        ovf_o   = evt_i & ~clr_i & (({1'b0, nxt} & mask) == '0);
        if (clr_i)      st_d.cnt = '0;
        else if (evt_i) st_d.cnt = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R12
    psc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> st_q.cnt == '0);
endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
    parameter int WDT_LIMIT = 1024,
    localparam int CW       = $clog2(WDT_LIMIT)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc_i,
    input  logic clr_i,
    input  logic sleep_i,
    input  logic mclr_i,
    output logic expire_o,
    output logic rst_o,
    output logic to_o,
    output logic pd_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          to;
        logic          pd;
        logic          asleep;
        logic          rst;
    } st_t;

    localparam st_t ST_POR = '{cnt: '0, to: 1'b1, pd: 1'b1, asleep: 1'b0, rst: 1'b0};

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.rst = 1'b0;
        expire_o = inc_i & (st_q.cnt == CW'(WDT_LIMIT - 1))
                   & ~clr_i & ~sleep_i & ~mclr_i;
        if (mclr_i) begin
            st_d.cnt    = '0;
            st_d.asleep = 1'b0;
            if (st_q.asleep) begin
                st_d.to = 1'b1;
                st_d.pd = 1'b0;
            end
        end else if (expire_o) begin
            st_d.cnt    = '0;
            st_d.rst    = 1'b1;
            st_d.to     = 1'b0;
            st_d.pd     = ~st_q.asleep;
            st_d.asleep = 1'b0;
        end else if (sleep_i) begin
            st_d.cnt    = '0;
            st_d.to     = 1'b1;
            st_d.pd     = 1'b0;
            st_d.asleep = 1'b1;
        end else if (clr_i) begin
            st_d.cnt = '0;
            st_d.to  = 1'b1;
            st_d.pd  = 1'b1;
        end else if (inc_i) begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_POR;
        else        st_q <= st_d;
    end

    assign rst_o = st_q.rst;
    assign to_o  = st_q.to;
    assign pd_o  = st_q.pd;

    // R6
    wdt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.cnt) < WDT_LIMIT);
    // R7
    clr_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i && !sleep_i && !mclr_i |=> to_o && pd_o);
    // R8
    sleep_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i && !mclr_i |=> to_o && !pd_o);
    // R9
    mclr_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mclr_i && st_q.asleep |=> to_o && !pd_o);
endmodule

// File: rtl/tmr_wdt_unit.sv
module tmr_wdt_unit
    import tmr_wdt_pkg::*;
#(
    parameter int TMR_W       = 8,
    parameter int PSC_W       = 8,
    parameter int WDT_LIMIT   = 1024,
    parameter int SYNC_STAGES = 2,
    localparam int SHW        = $clog2(PSC_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_stb_i,
    input  logic             ext_pin_i,
    input  logic             wdt_tick_i,
    input  logic             mode_we_i,
    input  logic [5:0]       mode_wdata_i,
    input  logic             tmr_we_i,
    input  logic [TMR_W-1:0] tmr_wdata_i,
    input  logic             clrwdt_i,
    input  logic             sleep_i,
    input  logic             mclr_i,
    output logic [TMR_W-1:0] tmr_o,
    output logic             wdt_rst_o,
    output logic             to_o,
    output logic             pd_o
);
    typedef struct packed {
        mode_t            mode;
        logic [TMR_W-1:0] tmr;
    } st_t;

    st_t st_d, st_q;

    logic           pin_evt, src_evt, psc_evt, psc_ovf, psc_clr;
    logic           tmr_inc, wdt_inc, wdt_expire;
    logic [SHW-1:0] psc_shift;

    pin_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (ext_pin_i),
        .fall_sel_i(st_q.mode.fall_edge),
        .edge_o    (pin_evt)
    );

    shared_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (psc_clr),
        .evt_i  (psc_evt),
        .shift_i(psc_shift),
        .ovf_o  (psc_ovf)
    );

    wdog_core #(.WDT_LIMIT(WDT_LIMIT)) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (wdt_inc),
        .clr_i   (clrwdt_i),
        .sleep_i (sleep_i),
        .mclr_i  (mclr_i),
        .expire_o(wdt_expire),
        .rst_o   (wdt_rst_o),
        .to_o    (to_o),
        .pd_o    (pd_o)
    );

    always_comb begin
        st_d    = st_q;
        src_evt = st_q.mode.ext_src ? pin_evt : cyc_stb_i;
        if (st_q.mode.psc_to_wdt) begin
            psc_evt   = wdt_tick_i;
            psc_shift = SHW'(st_q.mode.ratio_sel);
            tmr_inc   = src_evt;
            wdt_inc   = psc_ovf;
        end else begin
            psc_evt   = src_evt;
            psc_shift = SHW'(st_q.mode.ratio_sel) + SHW'(1);
            tmr_inc   = psc_ovf;
            wdt_inc   = wdt_tick_i;
        end
        psc_clr = mclr_i
                | (tmr_we_i & ~st_q.mode.psc_to_wdt)
                | ((clrwdt_i | sleep_i) & st_q.mode.psc_to_wdt)
                | (mode_we_i & (mode_wdata_i[3] != st_q.mode.psc_to_wdt));

        if (mclr_i || wdt_expire) st_d.mode = MODE_POR;
        else if (mode_we_i)       st_d.mode = mode_t'(mode_wdata_i);

        if (tmr_we_i)     st_d.tmr = tmr_wdata_i;
        else if (tmr_inc) st_d.tmr = st_q.tmr + TMR_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode <= MODE_POR;
            st_q.tmr  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tmr_o = st_q.tmr;

    // R5
    tmr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_we_i |=> tmr_o == $past(tmr_wdata_i));
    // R10
    timeout_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_o |-> st_q.mode == MODE_POR);
endmodule

// File: tb/tb_tmr_wdt_unit.sv
module tb_tmr_wdt_unit;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_stb = 0, ext_pin = 0, wdt_tick = 0, mode_we = 0;
    logic [5:0] mode_wdata = '0;
    logic       tmr_we = 0, clrwdt = 0, sleep = 0, mclr = 0;
    logic [7:0] tmr_wdata = '0;
    logic [7:0] tmr;
    logic       wdt_rst, to_f, pd_f;
    int         n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_wdt_unit #(.WDT_LIMIT(LIMIT)) dut (
        .clk(clk), .rst_n(rst_n), .cyc_stb_i(cyc_stb), .ext_pin_i(ext_pin),
        .wdt_tick_i(wdt_tick), .mode_we_i(mode_we), .mode_wdata_i(mode_wdata),
        .tmr_we_i(tmr_we), .tmr_wdata_i(tmr_wdata), .clrwdt_i(clrwdt),
        .sleep_i(sleep), .mclr_i(mclr), .tmr_o(tmr), .wdt_rst_o(wdt_rst),
        .to_o(to_f), .pd_o(pd_f)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    task automatic cyc(input int n);
        cyc_stb = 1; repeat (n) @(negedge clk); cyc_stb = 0;
    endtask
    task automatic wtick(input int n);
        wdt_tick = 1; repeat (n) @(negedge clk); wdt_tick = 0;
    endtask
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic wr_mode(input logic [5:0] v);
        mode_we = 1; mode_wdata = v; @(negedge clk); mode_we = 0;
    endtask
    task automatic wr_tmr(input logic [7:0] v);
        tmr_we = 1; tmr_wdata = v; @(negedge clk); tmr_we = 0;
    endtask
    task automatic do_clrwdt();
        clrwdt = 1; @(negedge clk); clrwdt = 0;
    endtask
    task automatic do_sleep();
        sleep = 1; @(negedge clk); sleep = 0;
    endtask
    task automatic do_mclr();
        mclr = 1; @(negedge clk); mclr = 0;
    endtask

    task automatic t_reset();
        check("R1 timer", tmr, 0);
        check("R1 TO", to_f, 1);
        check("R1 PD", pd_f, 1);
        wr_tmr(8'h00); cyc(3);
        check("R1 mode external source", tmr, 0);
    endtask

    task automatic t_internal();
        wr_mode(6'b001000); wr_tmr(0); cyc(5);
        check("R2 direct count", tmr, 5);
    endtask

    task automatic t_tmr_ratio();
        wr_mode(6'b000001); wr_tmr(0); cyc(7);
        check("R3 1:4 after 7", tmr, 1);
        cyc(1); check("R3 1:4 after 8", tmr, 2);
        cyc(8); check("R3 1:4 after 16", tmr, 4);
        wr_mode(6'b000000); wr_tmr(8'd10); cyc(3);
        check("R3 1:2 after 3", tmr, 11);
    endtask

    task automatic t_reassign();
        wr_mode(6'b000111); wr_tmr(0); cyc(200);
        check("R3 1:256 partial", tmr, 0);
        wr_mode(6'b001111); wr_mode(6'b000111); cyc(56);
        check("R12 prescaler cleared", tmr, 0);
        cyc(200); check("R12 full period", tmr, 1);
    endtask

    task automatic t_write();
        wr_mode(6'b001000);
        cyc_stb = 1; tmr_we = 1; tmr_wdata = 8'h80; @(negedge clk);
        cyc_stb = 0; tmr_we = 0;
        check("R5 write wins", tmr, 8'h80);
        wr_mode(6'b000010); wr_tmr(0); cyc(5); wr_tmr(8'h20); cyc(7);
        check("R5 write clears prescaler", tmr, 8'h20);
        cyc(1); check("R5 after clear", tmr, 8'h21);
    endtask

    task automatic t_extpin();
        wr_mode(6'b101000); wr_tmr(0);
        ext_pin = 1; idle(2);
        check("R4 latency two edges", tmr, 0);
        idle(1); check("R4 third edge", tmr, 1);
        cyc(4); check("R11 strobe ignored", tmr, 1);
        ext_pin = 0; idle(4); check("R4 falling ignored", tmr, 1);
        wr_mode(6'b111000);
        ext_pin = 1; idle(4); check("R4 rising ignored", tmr, 1);
        ext_pin = 0; idle(4); check("R4 falling counted", tmr, 2);
    endtask

    task automatic t_timeout();
        wr_mode(6'b001001); do_clrwdt(); wtick(7);
        check("R6 no timeout yet", wdt_rst, 0);
        wtick(1);
        check("R6 pulse", wdt_rst, 1);
        check("R6 TO", to_f, 0);
        check("R6 PD", pd_f, 1);
        idle(1); check("R6 one cycle", wdt_rst, 0);
        wr_tmr(0); cyc(3);
        check("R10 source back to pin", tmr, 0);
        ext_pin = 1; idle(4); ext_pin = 0; idle(4);
        check("R10 falling edge restored", tmr, 1);
    endtask

    task automatic t_raw_wdt();
        wr_mode(6'b000111); do_clrwdt(); wtick(3);
        check("R11 raw ticks no timeout", wdt_rst, 0);
        wtick(1); check("R11 raw ticks timeout", wdt_rst, 1);
    endtask

    task automatic t_clrwdt();
        wr_mode(6'b001000); do_clrwdt();
        check("R7 TO", to_f, 1);
        check("R7 PD", pd_f, 1);
        wtick(3); do_clrwdt(); wtick(3);
        check("R7 count restarted", wdt_rst, 0);
        wtick(1); check("R7 timeout after restart", wdt_rst, 1);
    endtask

    task automatic t_sleep();
        wr_mode(6'b001000); do_clrwdt(); wtick(2); do_sleep();
        check("R8 TO", to_f, 1);
        check("R8 PD", pd_f, 0);
        wtick(3); check("R8 count restarted", wdt_rst, 0);
        wtick(1);
        check("R8 timeout in sleep", wdt_rst, 1);
        check("R8 TO after wake", to_f, 0);
        check("R8 PD after wake", pd_f, 0);
    endtask

    task automatic t_mclr();
        wr_mode(6'b001000); do_clrwdt(); do_sleep(); do_mclr();
        check("R9 TO in sleep", to_f, 1);
        check("R9 PD in sleep", pd_f, 0);
        wr_tmr(0); cyc(3);
        check("R9 mode restored", tmr, 0);
        wr_mode(6'b001000); do_clrwdt(); wtick(4);
        do_mclr();
        check("R9 TO awake unchanged", to_f, 0);
        check("R9 PD awake unchanged", pd_f, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_internal();
        t_tmr_ratio();
        t_reassign();
        t_write();
        t_extpin();
        t_timeout();
        t_raw_wdt();
        t_clrwdt();
        t_sleep();
        t_mclr();
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end
endmodule